// File: doc/BRIEF.md
# Receive Ring Buffer Packet Writer

This block stores incoming frames into a circular buffer memory that is organised in pages of 256 bytes. A frame is offered with its byte length. It is accepted only when the ring has room for a frame of the largest size. The bytes then arrive as a stream and are written one per clock from the fifth byte of the current page onward. When the write address reaches the end of the ring it continues at the first byte of the ring.

Frames shorter than 60 bytes are filled with zero bytes up to 60. After the frame body the block writes a 4-byte descriptor into the first four bytes of the page where the frame began. The descriptor holds a status byte, the page where the following frame will start, and the stored length. The block then moves its current-page pointer to that following page and pulses a receive-done output that can drive an interrupt request.

The ring limits (first page, end page) and the boundary page where software is still reading come in as register inputs. Software can also load the current page directly.

Top module: `rxring_writer`

## Requirements
- R1: A frame whose length L is below 60 is stored as 60 bytes: the L stream bytes followed by 60−L zero bytes. Longer frames are stored as received. The stored body length is P = max(L, 60).
- R2: After the body, the block writes four descriptor bytes at page-relative offsets 0, 1, 2 and 3 of the page where the frame began. Offset 0 holds the status byte. Offset 1 holds the following-frame page. Offsets 2 and 3 hold T = P + 4, with the low byte at offset 2.
- R3: The status byte is 0x01. Bit 5 (value 0x20) is also set when bit 0 of the first stored body byte is 1.
- R4: The following-frame page is the current page C plus ceil((T + 4) / 256). If this value is at or beyond the end page, (end − first) is subtracted from it.
- R5: Body byte i goes to byte address C·256 + 4 + i. An address that reaches end·256 continues at first·256. Every frame makes exactly P + 4 memory writes, and no write falls outside the ring.
- R6: When a frame completes, `rx_done` is high for exactly one cycle, and `cur_pg` holds the following-frame page from the next cycle on.
- R7: `rx_ready` is high only when the writer is idle, `enable` is 1, and the free space is at least 1518 bytes. The free space is (B − C)·256 when C < B, and otherwise ((end − first) − (C − B))·256, where B is `bound_pg`.
- R8: `frm_start` while `rx_ready` is low is ignored. No memory write takes place and `cur_pg` does not change.
- R9: `cur_load` sets `cur_pg` to `cur_load_pg` on the next clock edge when no frame is completing.
- R10: `byte_ready` is high only during the body phase while stream bytes remain. A stream byte is taken on each clock edge where both `byte_valid` and `byte_ready` are high, and the write waits while `byte_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Receiver running; 0 refuses every frame |
| start_pg | input | ADDR_W-8 | First page of the ring |
| stop_pg | input | ADDR_W-8 | Page just past the ring |
| bound_pg | input | ADDR_W-8 | Oldest page not yet released by software |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_pg | input | ADDR_W-8 | Value loaded into the current page |
| cur_pg | output | ADDR_W-8 | Page where the next frame will be stored |
| frm_start | input | 1 | Offer of a new frame |
| frm_len | input | LEN_W | Byte length of the offered frame |
| rx_ready | output | 1 | Idle and enough room for a largest frame |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| byte_ready | output | 1 | Writer takes a stream byte this cycle |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | ADDR_W | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write data |
| rx_done | output | 1 | One-cycle pulse at frame completion |

## Verification
The assertions rely on a consistent ring setup: the first page is below the end page, the current page and the boundary page both lie inside the ring, and offered lengths do not exceed 1514 bytes. Under those conditions the address checks and the pointer checks mean something. The stimulus keeps to these limits. It loads the current page only while the writer is idle, and it holds the ring limits constant for the whole run. Within these limits it sweeps every current-page and boundary-page pair of a 12-page ring, and it places frames so that bodies and page rounding cross the ring end.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int PAGE_BYTES = 256;
    localparam int MIN_BODY   = 60;
    localparam int MAX_BODY   = 1514;
    localparam int DESC_BYTES = 4;
    localparam int CRC_SLACK  = 4;
    localparam int ROOM_BYTES = MAX_BODY + DESC_BYTES;

    localparam logic [7:0] ST_OK_BIT  = 8'h01;
    localparam logic [7:0] ST_GRP_BIT = 8'h20;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_BODY,
        WR_DESC,
        WR_FIN
    } wr_state_t;

    typedef struct packed {
        logic [15:0] body_len;
        logic [15:0] padded_len;
        logic [15:0] total_len;
    } frame_size_t;

    function automatic frame_size_t size_frame(input logic [15:0] len);
        frame_size_t s;
        s.body_len   = len;
        s.padded_len = (len < 16'(MIN_BODY)) ? 16'(MIN_BODY) : len;
        s.total_len  = s.padded_len + 16'(DESC_BYTES);
        return s;
    endfunction

    function automatic logic [15:0] page_span(input logic [15:0] total);
        logic [16:0] t;
        t = {1'b0, total} + 17'(CRC_SLACK + PAGE_BYTES - 1);
        return {7'd0, t[16:8]};
    endfunction

endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
    parameter int PG_W = 8
) (
    input  logic            enable,
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bound_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            room_ok
);
    import rxring_pkg::*;

    localparam int FB_W = PG_W + 9;

    logic [PG_W-1:0] ring_pages;
    logic [PG_W-1:0] free_pages;
    logic [FB_W-1:0] free_bytes;

    always_comb begin
        ring_pages = stop_pg - start_pg;
        if (cur_pg < bound_pg)
            free_pages = bound_pg - cur_pg;
        else
            free_pages = ring_pages - (cur_pg - bound_pg);
        free_bytes = {1'b0, free_pages, 8'h00};
        room_ok    = enable && (free_bytes >= FB_W'(ROOM_BYTES));
    end

endmodule

// File: rtl/rxring_link.sv
module rxring_link #(
    parameter int PG_W = 8
) (
    input  logic [PG_W-1:0] cur_pg,
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W:0]   span,
    output logic [PG_W-1:0] next_pg
);
    logic [PG_W:0] raw;
    logic [PG_W:0] fixed;

    always_comb begin
        raw = {1'b0, cur_pg} + span;
        if (raw >= {1'b0, stop_pg})
            fixed = raw - ({1'b0, stop_pg} - {1'b0, start_pg});
        else
            fixed = raw;
        next_pg = fixed[PG_W-1:0];
    end

endmodule

// File: rtl/rxring_addr.sv
module rxring_addr #(
    parameter int ADDR_W = 16,
    parameter int PG_W   = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W:0] bumped;
    logic [ADDR_W:0] wrap_at;

    always_comb begin
        bumped  = {1'b0, addr} + 1'b1;
        wrap_at = {1'b0, stop_pg, 8'h00};
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (step) begin
            if (bumped == wrap_at)
                addr <= {start_pg, 8'h00};
            else
                addr <= bumped[ADDR_W-1:0];
        end
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr == $past(addr) + 1'b1) || (addr == {start_pg, 8'h00}));

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [ADDR_W-9:0]   start_pg,
    input  logic [ADDR_W-9:0]   stop_pg,
    input  logic [ADDR_W-9:0]   bound_pg,
    input  logic                cur_load,
    input  logic [ADDR_W-9:0]   cur_load_pg,
    output logic [ADDR_W-9:0]   cur_pg,
    input  logic                frm_start,
    input  logic [LEN_W-1:0]    frm_len,
    output logic                rx_ready,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    output logic                byte_ready,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    output logic                rx_done
);
    import rxring_pkg::*;

    localparam int PG_W = ADDR_W - 8;

    wr_state_t         state_q;
    frame_size_t       fr_q;
    frame_size_t       fr_new;
    logic [15:0]       cnt_q;
    logic [PG_W-1:0]   base_q;
    logic [PG_W-1:0]   nxt_q;
    logic [PG_W-1:0]   link_pg;
    logic [PG_W-1:0]   cur_q;
    logic              grp_q;
    logic [1:0]        hidx_q;
    logic              room_ok;
    logic              accept;
    logic              real_byte;
    logic              body_we;
    logic              body_last;
    logic [7:0]        body_byte;
    logic [7:0]        desc_byte;
    logic [15:0]       span16;
    logic [ADDR_W-1:0] ptr_addr;

    always_comb begin
        fr_new = size_frame(16'(frm_len));
        span16 = page_span(fr_new.total_len);
    end

    rxring_space #(.PG_W(PG_W)) space_i (
        .enable  (enable),
        .start_pg(start_pg),
        .stop_pg (stop_pg),
        .bound_pg(bound_pg),
        .cur_pg  (cur_q),
        .room_ok (room_ok)
    );

    rxring_link #(.PG_W(PG_W)) link_i (
        .cur_pg  (cur_q),
        .start_pg(start_pg),
        .stop_pg (stop_pg),
        .span    (span16[PG_W:0]),
        .next_pg (link_pg)
    );

    rxring_addr #(.ADDR_W(ADDR_W), .PG_W(PG_W)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_addr({cur_q, 8'h04}),
        .step     (body_we),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .addr     (ptr_addr)
    );

    always_comb begin
        rx_ready   = (state_q == WR_IDLE) && room_ok;
        accept     = frm_start && rx_ready;
        real_byte  = cnt_q < fr_q.body_len;
        byte_ready = (state_q == WR_BODY) && real_byte;
        body_we    = (state_q == WR_BODY) && (real_byte ? byte_valid : 1'b1);
        body_byte  = real_byte ? byte_data : 8'h00;
        body_last  = body_we && (cnt_q == fr_q.padded_len - 16'd1);
        case (hidx_q)
            2'd0:    desc_byte = ST_OK_BIT | (grp_q ? ST_GRP_BIT : 8'h00);
            2'd1:    desc_byte = 8'(nxt_q);
            2'd2:    desc_byte = fr_q.total_len[7:0];
            default: desc_byte = fr_q.total_len[15:8];
        endcase
        mem_we    = body_we || (state_q == WR_DESC);
        mem_addr  = (state_q == WR_DESC) ? {base_q, 6'd0, hidx_q} : ptr_addr;
        mem_wdata = (state_q == WR_DESC) ? desc_byte : body_byte;
        rx_done   = (state_q == WR_FIN);
        cur_pg    = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            fr_q    <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
            nxt_q   <= '0;
            grp_q   <= 1'b0;
            hidx_q  <= '0;
        end else begin
            case (state_q)
                WR_IDLE: if (accept) begin
                    fr_q    <= fr_new;
                    base_q  <= cur_q;
                    nxt_q   <= link_pg;
                    cnt_q   <= '0;
                    grp_q   <= 1'b0;
                    state_q <= WR_BODY;
                end
                WR_BODY: if (body_we) begin
                    cnt_q <= cnt_q + 16'd1;
                    if (cnt_q == 16'd0)
                        grp_q <= body_byte[0];
                    if (body_last) begin
                        hidx_q  <= '0;
                        state_q <= WR_DESC;
                    end
                end
                WR_DESC: begin
                    hidx_q <= hidx_q + 2'd1;
                    if (hidx_q == 2'd3)
                        state_q <= WR_FIN;
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (state_q == WR_FIN)
            cur_q <= nxt_q;
        else if (cur_load)
            cur_q <= cur_load_pg;
    end

    // R5
    ring_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr >= {start_pg, 8'h00}) && (mem_addr < {stop_pg, 8'h00}));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    // R6
    cur_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (cur_pg >= start_pg) && (cur_pg < stop_pg));

    // R8
    no_room_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == WR_IDLE && !room_ok) |=> (state_q == WR_IDLE) && !mem_we);

    // R10
    ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> !rx_ready && !rx_done);

endmodule

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb_top;

    localparam int ADDR_W = 12;
    localparam int LEN_W  = 11;
    localparam int PG_W   = ADDR_W - 8;
    localparam int FIRST  = 2;
    localparam int LAST   = 14;
    localparam int RING   = LAST - FIRST;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic [PG_W-1:0]   start_pg = PG_W'(FIRST);
    logic [PG_W-1:0]   stop_pg  = PG_W'(LAST);
    logic [PG_W-1:0]   bound_pg = PG_W'(FIRST);
    logic              cur_load = 1'b0;
    logic [PG_W-1:0]   cur_load_pg = '0;
    logic [PG_W-1:0]   cur_pg;
    logic              frm_start = 1'b0;
    logic [LEN_W-1:0]  frm_len = '0;
    logic              rx_ready;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              byte_ready;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              rx_done;

    int compared = 0;
    int mismatched = 0;
    int wr_cnt = 0;
    logic [7:0] bmem [0:(1<<ADDR_W)-1];

    always #5 clk = ~clk;

    rxring_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .start_pg(start_pg), .stop_pg(stop_pg), .bound_pg(bound_pg),
        .cur_load(cur_load), .cur_load_pg(cur_load_pg), .cur_pg(cur_pg),
        .frm_start(frm_start), .frm_len(frm_len), .rx_ready(rx_ready),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rx_done(rx_done)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + 1) & 255);
    endfunction

    function automatic int ring_addr(input int cur, input int i);
        int a;
        a = cur * 256 + 4 + i;
        if (a >= LAST * 256) a -= RING * 256;
        return a;
    endfunction

    task automatic load_cur(input int c);
        cur_load = 1'b1;
        cur_load_pg = PG_W'(c);
        @(negedge clk);
        cur_load = 1'b0;
        chk(int'(cur_pg) == c, "R9 cur load", int'(cur_pg), c);
    endtask

    task automatic run_frame(input int cur, input int len, input int seed);
        int pad, tot, span, nx, snap, idx, guard, k, bad_body, bad_pad, first, st;
        pad  = (len < 60) ? 60 : len;
        tot  = pad + 4;
        span = (tot + 4 + 255) / 256;
        nx   = cur + span;
        if (nx >= LAST) nx -= RING;
        load_cur(cur);
        bound_pg = PG_W'(cur);
        @(negedge clk);
        chk(rx_ready == 1'b1, "R7 ready with full ring", int'(rx_ready), 1);
        snap = wr_cnt;
        frm_len = LEN_W'(len);
        frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
        idx = 0; guard = 0; k = 0;
        while (!rx_done && guard < 5000) begin
            byte_valid = (idx < len) && ((k % 5) != 3);
            byte_data  = pay(idx, seed);
            if (byte_ready && byte_valid) idx++;
            @(negedge clk);
            k++; guard++;
        end
        byte_valid = 1'b0;
        chk(rx_done == 1'b1, "R6 done pulse seen", int'(rx_done), 1);
        chk(idx == len, "R10 stream bytes taken", idx, len);
        @(negedge clk);
        chk(rx_done == 1'b0, "R6 done lasts one cycle", int'(rx_done), 0);
        chk(int'(cur_pg) == nx, "R6 cur page advanced", int'(cur_pg), nx);
        chk(wr_cnt - snap == pad + 4, "R5 write count", wr_cnt - snap, pad + 4);
        first = (len > 0) ? int'(pay(0, seed)) : 0;
        st = 1 | (((first & 1) != 0) ? 32 : 0);
        chk(int'(bmem[cur*256]) == st, "R3 status byte", int'(bmem[cur*256]), st);
        chk(int'(bmem[cur*256+1]) == nx, "R4 next page in descriptor", int'(bmem[cur*256+1]), nx);
        chk(int'(bmem[cur*256+2]) == (tot & 255), "R2 length low", int'(bmem[cur*256+2]), tot & 255);
        chk(int'(bmem[cur*256+3]) == (tot >> 8), "R2 length high", int'(bmem[cur*256+3]), tot >> 8);
        bad_body = -1; bad_pad = -1;
        for (int i = 0; i < pad; i++) begin
            if (i < len) begin
                if (bmem[ring_addr(cur, i)] !== pay(i, seed) && bad_body < 0) bad_body = i;
            end else begin
                if (bmem[ring_addr(cur, i)] !== 8'h00 && bad_pad < 0) bad_pad = i;
            end
        end
        chk(bad_body < 0, "R5 body placement", bad_body, -1);
        chk(bad_pad < 0, "R1 zero fill", bad_pad, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int snap, fr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(cur_pg == '0, "R9 reset page", int'(cur_pg), 0);
        chk(rx_done == 1'b0, "R6 reset done", int'(rx_done), 0);
        chk(mem_we == 1'b0, "R5 reset write", int'(mem_we), 0);
        chk(byte_ready == 1'b0, "R10 reset ready", int'(byte_ready), 0);
        chk(rx_ready == 1'b0, "R7 stopped refuses", int'(rx_ready), 0);
        enable = 1'b1;

        // R7 sweep of every current/boundary pair in the ring
        for (int c = FIRST; c < LAST; c++) begin
            load_cur(c);
            for (int b = FIRST; b < LAST; b++) begin
                bound_pg = PG_W'(b);
                #1;
                fr = (c < b) ? (b - c) * 256 : (RING - (c - b)) * 256;
                chk(rx_ready == (fr >= 1518), "R7 room check", int'(rx_ready), int'(fr >= 1518));
            end
        end
        enable = 1'b0;
        #1;
        chk(rx_ready == 1'b0, "R7 disabled", int'(rx_ready), 0);
        enable = 1'b1;
        @(negedge clk);

        // R8 offers without room are ignored
        load_cur(5);
        bound_pg = PG_W'(7);
        snap = wr_cnt;
        frm_len = LEN_W'(100);
        frm_start = 1'b1;
        repeat (3) @(negedge clk);
        frm_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(wr_cnt == snap, "R8 no writes", wr_cnt - snap, 0);
        chk(int'(cur_pg) == 5, "R8 page kept", int'(cur_pg), 5);
        chk(byte_ready == 1'b0, "R8 no body phase", int'(byte_ready), 0);

        // frames: padding, page rounding, ring wrap, group bit
        run_frame(2, 0, 1);
        run_frame(2, 1, 2);
        run_frame(5, 59, 3);
        run_frame(7, 60, 4);
        run_frame(9, 61, 5);
        run_frame(3, 248, 6);
        run_frame(3, 249, 7);
        run_frame(13, 252, 8);
        run_frame(12, 1514, 9);
        run_frame(11, 700, 10);
        run_frame(13, 1000, 11);
        run_frame(8, 512, 12);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule